// File: doc/BRIEF.md
# Serial Port Modem Control and Diagnostic Loopback

This block holds the modem-control register of a 16550-style serial port and performs the routing that the register selects. The CPU writes the register and reads it back. The register bits drive the two handshake outputs. One bit acts as an enable for the port's interrupt pad. Another bit is a spare flag that the CPU can read and write but that has no pin. The block sits between the port's pads and its core. On one side are the external serial input, the serial output, the modem status pins and the handshake outputs. On the other side are the transmit shift-register output, the receive shift-register input, and the modem-status lines that feed the status and interrupt logic.

Setting the loopback bit turns the port into a closed diagnostic loop. The serial output idles at mark and the external serial input is cut off. Transmitted bits go straight to the receiver. The four external status pins are ignored, and the four register output bits take their place internally. The real handshake pins go to their inactive level. Interrupt gating works the same way in both modes, so a driver can test its transmit, receive and modem-status paths without touching the line.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset every register bit is 0. The readback is 0, `dtr_n` and `rts_n` are 1, loopback is off and `irq_oe` is 0.
- R2: A write with `reg_wr` high stores data bits 0 to 4 on the next rising clock edge, and `reg_rdata` returns them. Bit layout: 0 = DTR, 1 = RTS, 2 = spare flag, 3 = interrupt enable, 4 = loopback. Bits 5 and up ignore writes and always read 0.
- R3: With loopback off, `dtr_n` is the inverse of bit 0 and `rts_n` is the inverse of bit 1 (the pins are active low).
- R4: With loopback off, `ser_out` follows `tx_shift_out`, `rx_shift_in` follows `ser_in`, and `ms_n` equals `ext_ms_n`. Line order in both: 0 = CTS, 1 = DSR, 2 = RI, 3 = DCD.
- R5: Bit 2 drives no pin. Changing it with loopback off leaves every output unchanged except `reg_rdata`.
- R6: `irq_oe` equals bit 3. While bit 3 is 1, `irq_o` follows `irq_req`. While bit 3 is 0, `irq_o` is 0 and the pad is released to high impedance.
- R7: With loopback on, `ser_out` is 1 (mark) and `ser_in` has no effect on any output.
- R8: With loopback on, `rx_shift_in` follows `tx_shift_out` in the same cycle.
- R9: With loopback on, `dtr_n` and `rts_n` are 1 whatever bits 0 and 1 hold.
- R10: With loopback on, `ext_ms_n` has no effect. The status lines are driven active low from the register: `ms_n[1]`(DSR) = ~bit0, `ms_n[0]`(CTS) = ~bit1, `ms_n[2]`(RI) = ~bit2, `ms_n[3]`(DCD) = ~bit3.
- R11: Interrupt gating by bit 3 works the same with loopback on as with it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DW (8) | Write data |
| reg_rdata | output | DW (8) | Register readback, reserved bits 0 |
| tx_shift_out | input | 1 | Transmit shift-register serial output |
| rx_shift_in | output | 1 | Serial input to the receive shift register |
| ser_in | input | 1 | External serial input pin |
| ser_out | output | 1 | External serial output pin |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| ext_ms_n | input | 4 | External modem status pins, active low: CTS, DSR, RI, DCD |
| ms_n | output | 4 | Modem status to the status/interrupt logic, same order and sense |
| irq_req | input | 1 | Interrupt request from the priority logic |
| irq_o | output | 1 | Interrupt pad data |
| irq_oe | output | 1 | Interrupt pad output enable (0 = high impedance) |

## Verification
Register-driven results appear one cycle after a write. The bench drives the write on a falling edge, the register captures it on the next rising edge, and the bench samples on the falling edge after that. The paths from `tx_shift_out`, `ser_in`, `ext_ms_n` and `irq_req` to the outputs are combinational. The bench changes those inputs and samples a short settle delay later, inside the same low clock phase. For every "has no effect" case, the bench toggles the ignored input and compares all affected outputs before the next stimulus.

// File: rtl/uart_mcr_pkg.sv
package uart_mcr_pkg;

  localparam int MCR_BITS = 5;
  localparam int MS_LINES = 4;

  // Stored control bits, MSB first: loop, irq enable, spare, rts, dtr
  typedef struct packed {
    logic loop;
    logic irq_en;
    logic spare;
    logic rts;
    logic dtr;
  } mcr_t;

  // Modem status line order
  typedef enum int {MS_CTS = 0, MS_DSR = 1, MS_RI = 2, MS_DCD = 3} ms_line_e;

  // Which control bit feeds a status line in loopback
  function automatic int lb_src(input int line);
    case (line)
      MS_CTS:  lb_src = 1;
      MS_DSR:  lb_src = 0;
      MS_RI:   lb_src = 2;
      default: lb_src = 3;
    endcase
  endfunction

endpackage

// File: rtl/mcr_rst_sync.sv
module mcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mcr_reg.sv
module mcr_reg
  import uart_mcr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output mcr_t          mcr,
  output logic [DW-1:0] rdata
);
  localparam int PAD_W = DW - MCR_BITS;

  mcr_t mcr_q;
  mcr_t mcr_d;
  logic mcr_en;

  always_comb begin
    mcr_en = wr;
    mcr_d  = mcr_t'(wdata[MCR_BITS-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mcr_q <= '0;
    else if (mcr_en) mcr_q <= mcr_d;
  end

  assign mcr   = mcr_q;
  assign rdata = {{PAD_W{1'b0}}, mcr_q};

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> rdata == {{PAD_W{1'b0}}, $past(wdata[MCR_BITS-1:0])});

  // R2
  no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(rdata));
endmodule

// File: rtl/mcr_lb_route.sv
module mcr_lb_route
  import uart_mcr_pkg::*;
(
  input  mcr_t                mcr,
  input  logic                tx_shift_out,
  output logic                rx_shift_in,
  input  logic                ser_in,
  output logic                ser_out,
  output logic                dtr_n,
  output logic                rts_n,
  input  logic [MS_LINES-1:0] ext_ms_n,
  output logic [MS_LINES-1:0] ms_n
);
  always_comb begin
    if (mcr.loop) begin
      ser_out     = 1'b1;
      rx_shift_in = tx_shift_out;
      dtr_n       = 1'b1;
      rts_n       = 1'b1;
    end else begin
      ser_out     = tx_shift_out;
      rx_shift_in = ser_in;
      dtr_n       = ~mcr.dtr;
      rts_n       = ~mcr.rts;
    end
  end

  for (genvar i = 0; i < MS_LINES; i++) begin : g_ms
    localparam int SRC = lb_src(i);
    assign ms_n[i] = mcr.loop ? ~mcr[SRC] : ext_ms_n[i];
  end
endmodule

// File: rtl/mcr_irq_gate.sv
module mcr_irq_gate (
  input  logic irq_en,
  input  logic irq_req,
  output logic irq_o,
  output logic irq_oe
);
  assign irq_oe = irq_en;
  assign irq_o  = irq_en & irq_req;
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_mcr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tx_shift_out,
  output logic          rx_shift_in,
  input  logic          ser_in,
  output logic          ser_out,
  output logic          dtr_n,
  output logic          rts_n,
  input  logic [3:0]    ext_ms_n,
  output logic [3:0]    ms_n,
  input  logic          irq_req,
  output logic          irq_o,
  output logic          irq_oe
);
  logic rst_n_s;
  mcr_t mcr;

  mcr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  mcr_reg #(.DW(DW)) u_reg (
    .clk(clk), .rst_n(rst_n_s), .wr(reg_wr), .wdata(reg_wdata),
    .mcr(mcr), .rdata(reg_rdata)
  );

  mcr_lb_route u_route (
    .mcr(mcr), .tx_shift_out(tx_shift_out), .rx_shift_in(rx_shift_in),
    .ser_in(ser_in), .ser_out(ser_out), .dtr_n(dtr_n), .rts_n(rts_n),
    .ext_ms_n(ext_ms_n), .ms_n(ms_n)
  );

  mcr_irq_gate u_irq (
    .irq_en(mcr.irq_en), .irq_req(irq_req), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // R7
  lb_mark_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_wr && reg_wdata[4] |=> ser_out);

  // R9
  lb_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_wr && reg_wdata[4] |=> dtr_n && rts_n);

  // R10
  lb_status_map_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_wr && reg_wdata[4] |=>
      ms_n == ~{$past(reg_wdata[3]), $past(reg_wdata[2]),
                $past(reg_wdata[0]), $past(reg_wdata[1])});

  // R6
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_wr && !reg_wdata[3] |=> !irq_oe && !irq_o);

  // R3
  norm_pins_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_wr && !reg_wdata[4] |=>
      dtr_n == !$past(reg_wdata[0]) && rts_n == !$past(reg_wdata[1]));
endmodule

// File: tb/uart_modem_ctl_bench.sv
`timescale 1ns/1ps
module uart_modem_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       tx_shift_out, rx_shift_in, ser_in, ser_out;
  logic       dtr_n, rts_n;
  logic [3:0] ext_ms_n, ms_n;
  logic       irq_req, irq_o, irq_oe;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  uart_modem_ctl u_uart_modem_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_shift_out(tx_shift_out),
    .rx_shift_in(rx_shift_in), .ser_in(ser_in), .ser_out(ser_out),
    .dtr_n(dtr_n), .rts_n(rts_n), .ext_ms_n(ext_ms_n), .ms_n(ms_n),
    .irq_req(irq_req), .irq_o(irq_o), .irq_oe(irq_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on falling edge, captured at rising edge, sample at next falling edge
  task automatic write_mcr(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 dtr_n/rts_n", {dtr_n, rts_n}, 2'b11);
    check("R1 irq_oe", irq_oe, 1'b0);
    tx_shift_out = 1'b0; settle();
    check("R1 loop off", ser_out, 1'b0);
  endtask

  task automatic t_rdwr();
    write_mcr(8'hFF);
    check("R2 reserved ignored", reg_rdata, 8'h1F);
    write_mcr(8'hEA);
    check("R2 pattern", reg_rdata, 8'h0A);
    write_mcr(8'h15);
    check("R2 pattern2", reg_rdata, 8'h15);
  endtask

  task automatic t_normal();
    write_mcr(8'h01);
    check("R3 dtr only", {dtr_n, rts_n}, 2'b01);
    write_mcr(8'h02);
    check("R3 rts only", {dtr_n, rts_n}, 2'b10);
    tx_shift_out = 1'b1; ser_in = 1'b0; ext_ms_n = 4'b1010; settle();
    check("R4 ser_out", ser_out, 1'b1);
    check("R4 rx_in", rx_shift_in, 1'b0);
    check("R4 ms", ms_n, 4'b1010);
    tx_shift_out = 1'b0; ser_in = 1'b1; ext_ms_n = 4'b0101; settle();
    check("R4 ser_out2", ser_out, 1'b0);
    check("R4 rx_in2", rx_shift_in, 1'b1);
    check("R4 ms2", ms_n, 4'b0101);
  endtask

  task automatic t_spare();
    write_mcr(8'h00);
    ext_ms_n = 4'b1100; tx_shift_out = 1'b1; irq_req = 1'b1; settle();
    write_mcr(8'h04);
    check("R5 rdata", reg_rdata, 8'h04);
    check("R5 outputs", {dtr_n, rts_n, ser_out, ms_n, irq_o, irq_oe},
          {1'b1, 1'b1, 1'b1, 4'b1100, 1'b0, 1'b0});
  endtask

  task automatic t_irq();
    write_mcr(8'h08);
    irq_req = 1'b1; settle();
    check("R6 enabled", {irq_oe, irq_o}, 2'b11);
    irq_req = 1'b0; settle();
    check("R6 follows", {irq_oe, irq_o}, 2'b10);
    irq_req = 1'b1;
    write_mcr(8'h00);
    check("R6 released", {irq_oe, irq_o}, 2'b00);
  endtask

  task automatic t_loop_serial();
    write_mcr(8'h13);
    tx_shift_out = 1'b0; ser_in = 1'b1; settle();
    check("R7 mark", ser_out, 1'b1);
    check("R8 loop rx0", rx_shift_in, 1'b0);
    tx_shift_out = 1'b1; ser_in = 1'b0; settle();
    check("R8 loop rx1", rx_shift_in, 1'b1);
    check("R7 mark2", ser_out, 1'b1);
    check("R9 pins idle", {dtr_n, rts_n}, 2'b11);
  endtask

  task automatic t_loop_modem();
    // dtr=1 only -> DSR (line1) active
    write_mcr(8'h11);
    ext_ms_n = 4'b0000; settle();
    check("R10 dtr->dsr", ms_n, 4'b1101);
    ext_ms_n = 4'b1111; settle();
    check("R10 ext ignored", ms_n, 4'b1101);
    write_mcr(8'h12);
    check("R10 rts->cts", ms_n, 4'b1110);
    write_mcr(8'h14);
    check("R10 spare->ri", ms_n, 4'b1011);
    write_mcr(8'h18);
    check("R10 en->dcd", ms_n, 4'b0111);
  endtask

  task automatic t_loop_irq();
    irq_req = 1'b1;
    write_mcr(8'h18);
    check("R11 loop enabled", {irq_oe, irq_o}, 2'b11);
    write_mcr(8'h10);
    check("R11 loop released", {irq_oe, irq_o}, 2'b00);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    tx_shift_out = 1'b1; ser_in = 1'b1; ext_ms_n = 4'hF; irq_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_rdwr();
    t_normal();
    t_spare();
    t_irq();
    t_loop_serial();
    t_loop_modem();
    t_loop_irq();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule